// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block holds six 32-bit event counters for a processor core, together with two control registers that set what each counter counts and how overflow is reported. Two per-cycle strobes feed it: one pulses on every core clock that should be counted as a cycle, and the other pulses when an instruction completes. Counters five and six have fixed roles. Counter five counts completed instructions and counter six counts cycles. Counters one to four each take an 8-bit event selector from the second control register. Code values that the decoder does not recognise leave a counter idle.

The first control register holds three freeze controls: a global one, one for the programmable group and one for the fixed group. It also holds two overflow-enable bits, an exception-enable bit and a sticky exception-pending flag. When a counter that is counting cycles, and whose overflow enable is set, moves from below 0x80000000 to at or above it, the block reports an overflow. If exceptions are enabled, it sets the pending flag, which drives the exception request output until software writes the flag back to zero.

Software reaches every counter and both control registers through a simple register port. A write takes effect at the next clock edge. Read data is combinational from the address.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, all six counters and both control registers read zero and `exc_req` is low.
- R2: Register addresses 0 to 5 select counters one to six, address 6 selects control register 0 and address 7 selects control register 1. Reads return the stored value. Control register 0 reads its seven defined bits (bits 0 to 6) and zeros above them. Addresses 8 and up read zero, and writes to them change nothing.
- R3: Counter five adds one for each cycle with `inst_done` high, and counter six adds one for each cycle with `cyc_tick` high. Neither depends on control register 1.
- R4: Counter k (k = 1 to 4) takes its selector from control register 1 bits [8k-1:8k-8]. Selector 0x02 counts `inst_done` and selector 0x1E counts `cyc_tick`.
- R5: Selector 0xF0 counts cycles and selector 0xFE counts instructions on counter one only. On counters two to four these codes count nothing, and every selector not named in R4 or R5 leaves the counter idle.
- R6: Control register 0 bit 0 set stops all six counters.
- R7: Control register 0 bit 1 set stops counters one to four only. Bit 2 set stops counters five and six only.
- R8: A counter that counts a cycle and so moves from below 0x80000000 to at or above it signals overflow once. It keeps counting upward without raising a second overflow. A software write of a value at or above the threshold makes the next counted cycle signal one overflow.
- R9: Overflow is signalled only by counters whose current event is cycles. Counter one uses enable bit 3 of control register 0, and counters two to six share enable bit 4.
- R10: An overflow sets the pending flag (control register 0 bit 6) only when exception enable (bit 5) is set. `exc_req` equals the pending flag, which stays set until software writes bit 6 to zero.
- R11: When a software write and an increment reach the same counter in the same cycle, the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | Cycle event strobe, one count per high cycle |
| inst_done | input | 1 | Instruction-completed strobe, one count per high cycle |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| exc_req | output | 1 | Exception request (pending flag) |

## Verification
The assertions check on every cycle that a write wins over a count and that the global freeze holds every counter still. They also check that the group freeze holds counters five and six, that the fixed counters add exactly their strobe, and that a set pending flag stays set until control register 0 is written. The selector decode is checked only by the bench, which sweeps all 256 codes on each programmable counter, and so is the whole grid of freeze combinations. The bench scenarios also cover the once-only overflow on a threshold crossing, the overflow after a negative write, the separate enable bits, the exclusion of instruction counters from overflow and the reserved addresses.

// File: rtl/pcu_pkg.sv
// Shared definitions for the performance monitor counter unit.
// Assumes an 8-bit selector field per programmable counter.
package pcu_pkg;
    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_INST = 2'd1,
        EV_CYC  = 2'd2
    } pcu_evt_e;

    // Bit positions in control register 0.
    localparam int unsigned C0_FRZ_ALL  = 0;
    localparam int unsigned C0_FRZ_PROG = 1;
    localparam int unsigned C0_FRZ_FIX  = 2;
    localparam int unsigned C0_OVE_ONE  = 3;
    localparam int unsigned C0_OVE_REST = 4;
    localparam int unsigned C0_EXC_EN   = 5;
    localparam int unsigned C0_PEND     = 6;
    localparam int unsigned C0_W        = 7;

    // Selector codes.
    localparam logic [7:0] SEL_INST     = 8'h02;
    localparam logic [7:0] SEL_CYC      = 8'h1E;
    localparam logic [7:0] SEL_CYC_ONE  = 8'hF0;
    localparam logic [7:0] SEL_INST_ONE = 8'hFE;
endpackage

// File: rtl/pcu_event_sel.sv
// Event selector decoder for one programmable counter.
// Maps a selector code to an event class. IS_FIRST enables the two
// codes that only the first counter understands.
module pcu_event_sel
    import pcu_pkg::*;
#(
    parameter int unsigned SEL_W    = 8,
    parameter bit          IS_FIRST = 1'b0
) (
    input  logic [SEL_W-1:0] sel,
    output pcu_evt_e         evt
);
    // Decode the selector into instruction, cycle or no event.
    always_comb begin
        evt = EV_NONE;
        if (sel == SEL_W'(SEL_INST)) begin
            evt = EV_INST;
        end else if (sel == SEL_W'(SEL_CYC)) begin
            evt = EV_CYC;
        end else if (IS_FIRST && (sel == SEL_W'(SEL_CYC_ONE))) begin
            evt = EV_CYC;
        end else if (IS_FIRST && (sel == SEL_W'(SEL_INST_ONE))) begin
            evt = EV_INST;
        end
    end
endmodule

// File: rtl/pcu_counter.sv
// One event counter with overflow edge detection.
// The counter loads on a write, which beats an increment in the same
// cycle. A tracking bit remembers whether the last counted value was
// at or above the threshold, so that only a crossing fires. A write
// clears that bit, so a negative value that was written fires on the
// next count.
module pcu_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             inc,
    input  logic             is_cyc,
    input  logic             ovf_en,
    output logic [CNT_W-1:0] value,
    output logic             ovf_fire
);
    localparam int unsigned MSB = CNT_W - 1;

    logic [CNT_W-1:0] next_val;
    logic             above_q;

    assign next_val = value + CNT_W'(1);

    // Count, load from software, and track the threshold state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value   <= '0;
            above_q <= 1'b0;
        end else if (wr_en) begin
            value   <= wr_data;
            above_q <= 1'b0;
        end else if (inc) begin
            value   <= next_val;
            above_q <= next_val[MSB];
        end
    end

    // Fire on an enabled cycle count that reaches the threshold.
    always_comb begin
        ovf_fire = !wr_en && inc && is_cyc && ovf_en
                   && next_val[MSB] && !above_q;
    end
endmodule

// File: rtl/pcu_regs.sv
// Control registers of the counter unit.
// Holds the freeze, overflow-enable and exception-enable fields of
// control register 0, the sticky pending flag, and the selector
// fields of control register 1. A software write of the pending bit
// beats a new overflow in the same cycle.
module pcu_regs
    import pcu_pkg::*;
#(
    parameter int unsigned SEL_ALL_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_c0,
    input  logic                 wr_c1,
    input  logic [C0_W-1:0]      wdata_c0,
    input  logic [SEL_ALL_W-1:0] wdata_c1,
    input  logic                 ovf_any,
    output logic                 frz_all,
    output logic                 frz_prog,
    output logic                 frz_fix,
    output logic                 ove_one,
    output logic                 ove_rest,
    output logic                 exc_en,
    output logic                 pending,
    output logic [SEL_ALL_W-1:0] sel_all
);
    // Store the enable and freeze fields of control register 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frz_all  <= 1'b0;
            frz_prog <= 1'b0;
            frz_fix  <= 1'b0;
            ove_one  <= 1'b0;
            ove_rest <= 1'b0;
            exc_en   <= 1'b0;
        end else if (wr_c0) begin
            frz_all  <= wdata_c0[C0_FRZ_ALL];
            frz_prog <= wdata_c0[C0_FRZ_PROG];
            frz_fix  <= wdata_c0[C0_FRZ_FIX];
            ove_one  <= wdata_c0[C0_OVE_ONE];
            ove_rest <= wdata_c0[C0_OVE_REST];
            exc_en   <= wdata_c0[C0_EXC_EN];
        end
    end

    // Sticky pending flag: set by an enabled overflow, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (wr_c0) begin
            pending <= wdata_c0[C0_PEND];
        end else if (ovf_any && exc_en) begin
            pending <= 1'b1;
        end
    end

    // Store the selector fields of control register 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_all <= '0;
        end else if (wr_c1) begin
            sel_all <= wdata_c1;
        end
    end
endmodule

// File: rtl/perf_counter_unit.sv
// Performance monitor counter unit: six event counters, two control
// registers and overflow-to-exception reporting.
// Assumes CNT_W is at least SEL_W*4 and at least seven, so that both
// control registers fit in the data word. Counters 1 to 4 are
// programmable, counter 5 counts instructions, counter 6 counts cycles.
module perf_counter_unit
    import pcu_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              inst_done,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              exc_req
);
    localparam int unsigned NUM_CNT    = 6;
    localparam int unsigned NUM_PROG   = 4;
    localparam int unsigned SEL_ALL_W  = SEL_W * NUM_PROG;
    localparam int unsigned ADDR_C0    = NUM_CNT;
    localparam int unsigned ADDR_C1    = NUM_CNT + 1;
    localparam int unsigned IDX_INST   = NUM_PROG;

    logic                     frz_all;
    logic                     frz_prog;
    logic                     frz_fix;
    logic                     ove_one;
    logic                     ove_rest;
    logic                     exc_en;
    logic                     pending;
    logic [SEL_ALL_W-1:0]     sel_all;
    logic [CNT_W-1:0]         cnt_val [NUM_CNT];
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;
    logic [NUM_CNT-1:0]       fire_vec;
    logic                     ovf_any;
    logic                     wr_c0;
    logic                     wr_c1;

    assign wr_c0   = reg_wr && (reg_addr == ADDR_W'(ADDR_C0));
    assign wr_c1   = reg_wr && (reg_addr == ADDR_W'(ADDR_C1));
    assign ovf_any = |fire_vec;
    assign exc_req = pending;

    pcu_regs #(
        .SEL_ALL_W(SEL_ALL_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_c0    (wr_c0),
        .wr_c1    (wr_c1),
        .wdata_c0 (reg_wdata[C0_W-1:0]),
        .wdata_c1 (reg_wdata[SEL_ALL_W-1:0]),
        .ovf_any  (ovf_any),
        .frz_all  (frz_all),
        .frz_prog (frz_prog),
        .frz_fix  (frz_fix),
        .ove_one  (ove_one),
        .ove_rest (ove_rest),
        .exc_en   (exc_en),
        .pending  (pending),
        .sel_all  (sel_all)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        pcu_evt_e evt;
        logic     grp_frz;
        logic     inc;
        logic     ove;
        logic     wr_me;

        if (i < NUM_PROG) begin : g_prog
            pcu_event_sel #(
                .SEL_W    (SEL_W),
                .IS_FIRST (i == 0)
            ) u_sel (
                .sel (sel_all[i*SEL_W +: SEL_W]),
                .evt (evt)
            );
            assign grp_frz = frz_all || frz_prog;
        end else begin : g_fixed
            assign evt     = (i == IDX_INST) ? EV_INST : EV_CYC;
            assign grp_frz = frz_all || frz_fix;
        end

        if (i == 0) begin : g_ove_one
            assign ove = ove_one;
        end else begin : g_ove_rest
            assign ove = ove_rest;
        end

        // Increment when the selected strobe is high and the group runs.
        always_comb begin
            inc = !grp_frz && (((evt == EV_CYC) && cyc_tick)
                             || ((evt == EV_INST) && inst_done));
        end

        assign wr_me = reg_wr && (reg_addr == ADDR_W'(i));

        pcu_counter #(
            .CNT_W(CNT_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_me),
            .wr_data  (reg_wdata),
            .inc      (inc),
            .is_cyc   (evt == EV_CYC),
            .ovf_en   (ove),
            .value    (cnt_val[i]),
            .ovf_fire (fire_vec[i])
        );

        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_val[i];
    end

    // Read multiplexer over the counters and both control registers.
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (reg_addr == ADDR_W'(k)) begin
                reg_rdata = cnt_val[k];
            end
        end
        if (reg_addr == ADDR_W'(ADDR_C0)) begin
            reg_rdata[C0_FRZ_ALL]  = frz_all;
            reg_rdata[C0_FRZ_PROG] = frz_prog;
            reg_rdata[C0_FRZ_FIX]  = frz_fix;
            reg_rdata[C0_OVE_ONE]  = ove_one;
            reg_rdata[C0_OVE_REST] = ove_rest;
            reg_rdata[C0_EXC_EN]   = exc_en;
            reg_rdata[C0_PEND]     = pending;
        end
        if (reg_addr == ADDR_W'(ADDR_C1)) begin
            reg_rdata[SEL_ALL_W-1:0] = sel_all;
        end
    end
endmodule

// File: rtl/pcu_checker.sv
// Assertion checker for the counter unit, attached by bind.
// Observes the register port, the strobes, the flattened counter
// values and the freeze fields.
module pcu_checker #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cyc_tick,
    input logic                inst_done,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [CNT_W-1:0]    reg_wdata,
    input logic                exc_req,
    input logic [6*CNT_W-1:0]  cnt_flat,
    input logic                frz_all,
    input logic                frz_fix
);
    logic [CNT_W-1:0] c5;
    logic [CNT_W-1:0] c6;
    logic             wr_cnt_any;

    assign c5         = cnt_flat[4*CNT_W +: CNT_W];
    assign c6         = cnt_flat[5*CNT_W +: CNT_W];
    assign wr_cnt_any = reg_wr && (reg_addr < ADDR_W'(6));

    for (genvar i = 0; i < 6; i++) begin : g_wr
        // R11: a write lands regardless of a same-cycle increment.
        a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == ADDR_W'(i))
            |=> cnt_flat[i*CNT_W +: CNT_W] == $past(reg_wdata));
    end

    // R6: global freeze holds every counter still.
    a_r6_global_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_all && !wr_cnt_any) |=> $stable(cnt_flat));

    // R7: fixed-group freeze holds counters five and six.
    a_r7_fixed_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_fix && !(reg_wr && (reg_addr == ADDR_W'(4) || reg_addr == ADDR_W'(5))))
        |=> ($stable(c5) && $stable(c6)));

    // R3: counter five adds exactly the instruction strobe.
    a_r3_inst_counter: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_all && !frz_fix && !(reg_wr && reg_addr == ADDR_W'(4)))
        |=> c5 == $past(c5) + CNT_W'($past(inst_done)));

    // R3: counter six adds exactly the cycle strobe.
    a_r3_cycle_counter: assert property (@(posedge clk) disable iff (!rst_n)
        (!frz_all && !frz_fix && !(reg_wr && reg_addr == ADDR_W'(5)))
        |=> c6 == $past(c6) + CNT_W'($past(cyc_tick)));

    // R10: the exception request is sticky until control register 0 is written.
    a_r10_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !(reg_wr && reg_addr == ADDR_W'(6))) |=> exc_req);
endmodule

bind perf_counter_unit pcu_checker #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_pcu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_tick  (cyc_tick),
    .inst_done (inst_done),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .exc_req   (exc_req),
    .cnt_flat  (cnt_flat),
    .frz_all   (frz_all),
    .frz_fix   (frz_fix)
);

// File: tb/perf_counter_unit_test.sv
`timescale 1ns/1ps
module perf_counter_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0;
    logic        inst_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        exc_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    perf_counter_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_tick  (cyc_tick),
        .inst_done (inst_done),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .exc_req   (exc_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick(input logic c, input logic i, input int n);
        @(negedge clk);
        cyc_tick = c; inst_done = i;
        repeat (n) @(negedge clk);
        cyc_tick = 1'b0; inst_done = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a,
                              input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, $sformatf("addr %0d", a), v, exp);
    endtask

    // Event class from the selector rules: 0 none, 1 instr, 2 cycles.
    function automatic int evt_of(input int k, input int sel);
        if (sel == 8'h02) return 1;
        if (sel == 8'h1E) return 2;
        if (k == 0 && sel == 8'hF0) return 2;
        if (k == 0 && sel == 8'hFE) return 1;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        for (int a = 0; a < 8; a++) expect_reg("R1", 4'(a), 32'h0);
        check("R1", "exc_req", {31'b0, exc_req}, 32'h0);

        // R2: readback and reserved addresses.
        wr(4'd7, 32'hA5C3_1E02);
        expect_reg("R2", 4'd7, 32'hA5C3_1E02);
        wr(4'd6, 32'hFFFF_FFFF);
        expect_reg("R2", 4'd6, 32'h0000_007F);
        check("R10", "exc_req after set", {31'b0, exc_req}, 32'h1);
        wr(4'd6, 32'h0);
        check("R10", "exc_req after clear", {31'b0, exc_req}, 32'h0);
        wr(4'd9, 32'hFFFF_FFFF);
        expect_reg("R2", 4'd9, 32'h0);
        expect_reg("R2", 4'd6, 32'h0);
        for (int a = 0; a < 6; a++) expect_reg("R2", 4'(a), 32'h0);

        // R4 R5: sweep every selector code on each programmable counter.
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 256; s++) begin
                int e;
                wr(4'd7, 32'(s) << (8 * k));
                wr(4'(k), 32'h0);
                tick(1'b1, 1'b0, 3);
                tick(1'b0, 1'b1, 5);
                e = evt_of(k, s);
                rd(4'(k), v);
                check((e == 0) ? "R5" : (s == 8'h02 || s == 8'h1E) ? "R4" : "R5",
                      $sformatf("counter %0d sel %h", k + 1, s), v,
                      (e == 1) ? 32'd5 : (e == 2) ? 32'd3 : 32'd0);
            end
        end

        // R3 R6 R7: every freeze combination, fixed and programmable counters.
        wr(4'd7, 32'h1EF0_021E);
        for (int f = 0; f < 8; f++) begin
            bit run_p;
            bit run_f;
            run_p = !f[0] && !f[1];
            run_f = !f[0] && !f[2];
            wr(4'd6, 32'(f));
            for (int a = 0; a < 6; a++) wr(4'(a), 32'h0);
            tick(1'b1, 1'b0, 4);
            tick(1'b0, 1'b1, 2);
            expect_reg(f[0] ? "R6" : "R7", 4'd0, run_p ? 32'd4 : 32'd0);
            expect_reg(f[0] ? "R6" : "R7", 4'd1, run_p ? 32'd2 : 32'd0);
            expect_reg("R5", 4'd2, 32'd0);
            expect_reg(f[0] ? "R6" : "R7", 4'd3, run_p ? 32'd4 : 32'd0);
            expect_reg(f == 0 ? "R3" : f[0] ? "R6" : "R7", 4'd4, run_f ? 32'd2 : 32'd0);
            expect_reg(f == 0 ? "R3" : f[0] ? "R6" : "R7", 4'd5, run_f ? 32'd4 : 32'd0);
        end

        // R8 R10: crossing on counter six fires once.
        wr(4'd6, 32'h30);
        wr(4'd5, 32'h7FFF_FFFE);
        tick(1'b1, 1'b0, 1);
        expect_reg("R8", 4'd5, 32'h7FFF_FFFF);
        check("R8", "no early overflow", {31'b0, exc_req}, 32'h0);
        tick(1'b1, 1'b0, 1);
        check("R8", "overflow on crossing", {31'b0, exc_req}, 32'h1);
        expect_reg("R8", 4'd5, 32'h8000_0000);
        expect_reg("R10", 4'd6, 32'h70);
        tick(1'b0, 1'b0, 3);
        check("R10", "pending held", {31'b0, exc_req}, 32'h1);
        wr(4'd6, 32'h30);
        tick(1'b1, 1'b0, 3);
        check("R8", "no second overflow", {31'b0, exc_req}, 32'h0);
        expect_reg("R8", 4'd5, 32'h8000_0003);
        wr(4'd5, 32'h9000_0000);
        check("R8", "write alone no overflow", {31'b0, exc_req}, 32'h0);
        tick(1'b1, 1'b0, 1);
        check("R8", "negative write then count", {31'b0, exc_req}, 32'h1);
        wr(4'd6, 32'h30);

        // R10: exception enable off keeps pending clear.
        wr(4'd6, 32'h10);
        wr(4'd5, 32'h7FFF_FFFF);
        tick(1'b1, 1'b0, 1);
        check("R10", "exc disabled", {31'b0, exc_req}, 32'h0);
        expect_reg("R10", 4'd6, 32'h10);

        // R9: counter one uses its own enable.
        wr(4'd6, 32'h30);
        wr(4'd5, 32'h0);
        wr(4'd0, 32'h7FFF_FFFF);
        tick(1'b1, 1'b0, 1);
        check("R9", "counter1 shared enable only", {31'b0, exc_req}, 32'h0);
        wr(4'd6, 32'h28);
        wr(4'd0, 32'h7FFF_FFFF);
        tick(1'b1, 1'b0, 1);
        check("R9", "counter1 own enable", {31'b0, exc_req}, 32'h1);
        wr(4'd6, 32'h38);
        check("R10", "cleared", {31'b0, exc_req}, 32'h0);

        // R9: an instruction counter crossing does not raise overflow.
        wr(4'd4, 32'h7FFF_FFFF);
        tick(1'b0, 1'b1, 1);
        expect_reg("R9", 4'd4, 32'h8000_0000);
        check("R9", "instr counter no overflow", {31'b0, exc_req}, 32'h0);
        wr(4'd6, 32'h0);

        // R11: write and increment in the same cycle.
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd5; reg_wdata = 32'h0000_1234; cyc_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; cyc_tick = 1'b0;
        expect_reg("R11", 4'd5, 32'h0000_1234);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0000_0077; inst_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; inst_done = 1'b0;
        expect_reg("R11", 4'd4, 32'h0000_0077);

        finish_run();
    end
endmodule